// File: doc/BRIEF.md
# Floating-Point Memory Ordering Queues

This block holds floating-point loads and stores between issue and memory. Instead of one reservation station, it keeps two ordered queues: one for loads and one for stores. The issue stage offers one memory operation per cycle. The operation enters its queue in program order and receives a program-order age tag from a counter that both queues share. Integer memory traffic never enters the block. Only floating-point memory operations can create a dependence between the integer and floating-point issue paths.

**Hazard checks at allocation.** When an entry is allocated, it compares its address against the other queue:
- A new load checks every resident store. A match is a read-after-write hazard.
- A new store checks every resident load, which catches write-after-read hazards.
- A new store also checks every resident store, which catches write-after-write hazards.

Only entries older than the new one are considered. The hazard is reported on `alloc_hazard`.

**Held entries and draining.** A conflicting entry is parked as held. It records the queue slot of the youngest older entry it conflicts with. Each queue drains strictly from its head. A held head therefore also blocks every younger entry in the same queue.

**Entry states.** Each entry slot runs a small state machine with three states:
- FREE: the slot is empty.
- HELD: allocated with at least one pending conflict.
- READY: free to drain.

The transitions are:
- ALLOC_CLEAN: FREE to READY.
- ALLOC_CONFLICT: FREE to HELD.
- RELEASE: HELD to READY, once every recorded blocker has retired.
- DRAIN: READY to FREE, when the head is accepted by memory.

When an entry retires, a registered retire notice is raised on the next edge. Held entries use that notice on the edge after, so release comes one cycle after retirement.

Top module: `fpmem_lsq`

## Requirements
- R1: While `rst` is high at a clock edge, all entries become FREE and both queue pointers and the age counter return to zero. After reset, `ld_mem_valid` and `st_mem_valid` are 0 and `alloc_ready` is 1 for either kind of operation.
- R2: Each queue holds DEPTH (8) entries. `alloc_ready` is 0 when the queue selected by `alloc_store` (1 = store, 0 = load) is full, and 1 otherwise. The state of the other queue does not affect it.
- R3: Loads are offered on `ld_mem_*` strictly in allocation order, with the address they were allocated with. A load is removed on an edge where `ld_mem_valid` and `ld_mem_ready` are both 1.
- R4: Stores are offered on `st_mem_*` strictly in allocation order, with the same valid/ready removal rule.
- R5: A load whose address equals that of any resident store is flagged on `alloc_hazard` and held. It and every younger load stay off `ld_mem_valid` until that store has retired.
- R6: A store whose address equals that of any resident load is flagged on `alloc_hazard` and held until that load has retired (write-after-read).
- R7: A store whose address equals that of any resident store is flagged on `alloc_hazard` and held until that store has retired (write-after-write).
- R8: If the last blocker of a held head entry retires on edge t, the held entry becomes READY on edge t+1. Its drain valid is 0 in the cycle between t and t+1 and 1 after t+1.
- R9: Every accepted allocation, of either kind, takes its 4-bit age tag from a shared counter. The counter starts at 0 after reset, increments by one per accepted allocation, and wraps from 15 to 0. The tag is shown on `ld_mem_age` or `st_mem_age`.
- R10: An operation whose address matches no resident entry raises no hazard. If it is at the head, it is offered for drain in the cycle after its allocation edge.
- R11: An entry that retires on the same edge as a new allocation is not treated as a conflict for that allocation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Issue stage offers a memory operation |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_addr | input | 32 | Memory address of the offered operation |
| alloc_ready | output | 1 | Target queue has room; the offer is taken on the edge |
| alloc_hazard | output | 1 | The accepted operation conflicts with an older entry |
| ld_mem_valid | output | 1 | Load queue head is ready for memory |
| ld_mem_ready | input | 1 | Memory accepts the load head |
| ld_mem_addr | output | 32 | Load head address |
| ld_mem_age | output | 4 | Load head age tag |
| st_mem_valid | output | 1 | Store queue head is ready for memory |
| st_mem_ready | input | 1 | Memory accepts the store head |
| st_mem_addr | output | 32 | Store head address |
| st_mem_age | output | 4 | Store head age tag |

## Verification
The bench fills each queue to its limit and sweeps the ready signal per fill level. A design with an off-by-one full flag would either drop the ninth entry or stall one entry early. Each hazard kind is staged with a deliberately stalled blocker, and the bench looks for the one-cycle bubble after release. A design that releases on the retirement edge itself would show no bubble, and one that missed the conflict would drain out of order. The age counter is driven across its wrap, and a store retiring on the same edge as a matching load allocation probes whether a departing entry is wrongly counted as a blocker.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_HELD  = 2'd1,
        ENT_READY = 2'd2
    } ent_state_e;

endpackage

// File: rtl/lsq_match.sv
// Address comparator: finds the youngest resident entry of one queue whose
// address equals a key and whose age is older than the key's age.
module lsq_match #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int AGE_W  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             occ,
    input  logic [DEPTH-1:0][ADDR_W-1:0] addrs,
    input  logic [DEPTH-1:0][AGE_W-1:0]  ages,
    input  logic [IDX_W-1:0]             head,
    input  logic                         head_leaving,
    input  logic [ADDR_W-1:0]            key_addr,
    input  logic [AGE_W-1:0]             key_age,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        // walk from oldest to youngest so the last match is the youngest
        for (int k = 0; k < DEPTH; k++) begin
            logic [IDX_W-1:0] jj;
            logic             older;
            jj    = head + IDX_W'(k);
            older = (AGE_W'(key_age - ages[jj]) != '0);
            if (occ[jj] && older && (addrs[jj] == key_addr)
                && !(head_leaving && (jj == head))) begin
                hit     = 1'b1;
                hit_idx = jj;
            end
        end
    end

endmodule

// File: rtl/lsq_queue.sv
// Ordered queue of memory operations with per-entry hold tracking.
module lsq_queue
    import lsq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int AGE_W  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         alloc_en,
    input  logic [ADDR_W-1:0]            alloc_addr,
    input  logic [AGE_W-1:0]             alloc_age,
    input  logic                         wa_vld,
    input  logic [IDX_W-1:0]             wa_idx,
    input  logic                         wb_vld,
    input  logic [IDX_W-1:0]             wb_idx,
    input  logic                         ra_vld,
    input  logic [IDX_W-1:0]             ra_idx,
    input  logic                         rb_vld,
    input  logic [IDX_W-1:0]             rb_idx,
    input  logic                         drain_rdy,
    output logic                         full,
    output logic                         out_vld,
    output logic [ADDR_W-1:0]            out_addr,
    output logic [AGE_W-1:0]             out_age,
    output logic                         pop,
    output logic [IDX_W-1:0]             head_idx,
    output logic [DEPTH-1:0]             occ,
    output logic [DEPTH-1:0][ADDR_W-1:0] addrs,
    output logic [DEPTH-1:0][AGE_W-1:0]  ages
);

    localparam int CNT_W = IDX_W + 1;

    ent_state_e                    st_q   [DEPTH];
    ent_state_e                    st_nxt [DEPTH];
    logic [DEPTH-1:0]              wa_q, wb_q;
    logic [DEPTH-1:0]              wa_nxt, wb_nxt;
    logic [DEPTH-1:0][IDX_W-1:0]   wa_idx_q, wb_idx_q;
    logic [DEPTH-1:0][ADDR_W-1:0]  addr_q;
    logic [DEPTH-1:0][AGE_W-1:0]   age_q;
    logic [IDX_W-1:0]              head_q, tail_q;
    logic [CNT_W-1:0]              cnt_q;

    // per-entry next state
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic alloc_here, pop_here, a_clr, b_clr;
            alloc_here = alloc_en && (tail_q == IDX_W'(i));
            pop_here   = pop && (head_q == IDX_W'(i));
            a_clr      = wa_q[i] && ra_vld && (ra_idx == wa_idx_q[i]);
            b_clr      = wb_q[i] && rb_vld && (rb_idx == wb_idx_q[i]);
            st_nxt[i]  = st_q[i];
            wa_nxt[i]  = wa_q[i] && !a_clr;
            wb_nxt[i]  = wb_q[i] && !b_clr;
            unique case (st_q[i])
                ENT_FREE: begin
                    if (alloc_here) begin
                        wa_nxt[i] = wa_vld;
                        wb_nxt[i] = wb_vld;
                        st_nxt[i] = (wa_vld || wb_vld) ? ENT_HELD : ENT_READY;
                    end
                end
                ENT_HELD: begin
                    if (!wa_nxt[i] && !wb_nxt[i])
                        st_nxt[i] = ENT_READY;
                end
                ENT_READY: begin
                    if (pop_here)
                        st_nxt[i] = ENT_FREE;
                end
                default: st_nxt[i] = ENT_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i] <= ENT_FREE;
            end
            wa_q   <= '0;
            wb_q   <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i] <= st_nxt[i];
            end
            wa_q <= wa_nxt;
            wb_q <= wb_nxt;
            if (alloc_en) tail_q <= tail_q + 1'b1;
            if (pop)      head_q <= head_q + 1'b1;
            if (alloc_en && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (!alloc_en && pop) cnt_q <= cnt_q - 1'b1;
        end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            addr_q[tail_q]   <= alloc_addr;
            age_q[tail_q]    <= alloc_age;
            wa_idx_q[tail_q] <= wa_idx;
            wb_idx_q[tail_q] <= wb_idx;
        end
    end

    // outputs
    always_comb begin
        full     = (cnt_q == CNT_W'(DEPTH));
        out_vld  = (st_q[head_q] == ENT_READY);
        out_addr = addr_q[head_q];
        out_age  = age_q[head_q];
        pop      = out_vld && drain_rdy;
        head_idx = head_q;
        addrs    = addr_q;
        ages     = age_q;
        for (int i = 0; i < DEPTH; i++) begin
            occ[i] = (st_q[i] != ENT_FREE);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !full); // R2

    for (genvar g = 0; g < DEPTH; g++) begin : g_rel
        AST_RELEASE_DELAY: assert property (@(posedge clk) disable iff (rst)
            (st_q[g] == ENT_HELD) |=>
                ((st_q[g] == ENT_HELD) || $past(ra_vld || rb_vld))); // R8
    end

endmodule

// File: rtl/fpmem_lsq.sv
module fpmem_lsq #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int AGE_W  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic              alloc_store,
    input  logic [ADDR_W-1:0] alloc_addr,
    output logic              alloc_ready,
    output logic              alloc_hazard,
    output logic              ld_mem_valid,
    input  logic              ld_mem_ready,
    output logic [ADDR_W-1:0] ld_mem_addr,
    output logic [AGE_W-1:0]  ld_mem_age,
    output logic              st_mem_valid,
    input  logic              st_mem_ready,
    output logic [ADDR_W-1:0] st_mem_addr,
    output logic [AGE_W-1:0]  st_mem_age
);

    logic [AGE_W-1:0] age_q;
    logic             ld_full, st_full, ld_alloc, st_alloc;
    logic             ld_pop, st_pop;
    logic [IDX_W-1:0] ld_head, st_head;
    logic [DEPTH-1:0] ld_occ, st_occ;
    logic [DEPTH-1:0][ADDR_W-1:0] ld_addrs, st_addrs;
    logic [DEPTH-1:0][AGE_W-1:0]  ld_ages, st_ages;
    logic             raw_hit, war_hit, waw_hit;
    logic [IDX_W-1:0] raw_idx, war_idx, waw_idx;
    logic             ld_ret_q, st_ret_q;
    logic [IDX_W-1:0] ld_ret_idx_q, st_ret_idx_q;

    assign ld_alloc     = alloc_valid && !alloc_store && !ld_full;
    assign st_alloc     = alloc_valid &&  alloc_store && !st_full;
    assign alloc_ready  = alloc_store ? !st_full : !ld_full;
    assign alloc_hazard = (ld_alloc && raw_hit) || (st_alloc && (war_hit || waw_hit));

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q        <= '0;
            ld_ret_q     <= 1'b0;
            st_ret_q     <= 1'b0;
            ld_ret_idx_q <= '0;
            st_ret_idx_q <= '0;
        end else begin
            if (ld_alloc || st_alloc) age_q <= age_q + 1'b1;
            ld_ret_q     <= ld_pop;
            st_ret_q     <= st_pop;
            ld_ret_idx_q <= ld_head;
            st_ret_idx_q <= st_head;
        end
    end

    lsq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_raw (
        .occ(st_occ), .addrs(st_addrs), .ages(st_ages), .head(st_head),
        .head_leaving(st_pop), .key_addr(alloc_addr), .key_age(age_q),
        .hit(raw_hit), .hit_idx(raw_idx));

    lsq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_war (
        .occ(ld_occ), .addrs(ld_addrs), .ages(ld_ages), .head(ld_head),
        .head_leaving(ld_pop), .key_addr(alloc_addr), .key_age(age_q),
        .hit(war_hit), .hit_idx(war_idx));

    lsq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_waw (
        .occ(st_occ), .addrs(st_addrs), .ages(st_ages), .head(st_head),
        .head_leaving(st_pop), .key_addr(alloc_addr), .key_age(age_q),
        .hit(waw_hit), .hit_idx(waw_idx));

    lsq_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_ldq (
        .clk(clk), .rst(rst),
        .alloc_en(ld_alloc), .alloc_addr(alloc_addr), .alloc_age(age_q),
        .wa_vld(raw_hit), .wa_idx(raw_idx),
        .wb_vld(1'b0), .wb_idx('0),
        .ra_vld(st_ret_q), .ra_idx(st_ret_idx_q),
        .rb_vld(1'b0), .rb_idx('0),
        .drain_rdy(ld_mem_ready), .full(ld_full),
        .out_vld(ld_mem_valid), .out_addr(ld_mem_addr), .out_age(ld_mem_age),
        .pop(ld_pop), .head_idx(ld_head),
        .occ(ld_occ), .addrs(ld_addrs), .ages(ld_ages));

    lsq_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_stq (
        .clk(clk), .rst(rst),
        .alloc_en(st_alloc), .alloc_addr(alloc_addr), .alloc_age(age_q),
        .wa_vld(war_hit), .wa_idx(war_idx),
        .wb_vld(waw_hit), .wb_idx(waw_idx),
        .ra_vld(ld_ret_q), .ra_idx(ld_ret_idx_q),
        .rb_vld(st_ret_q), .rb_idx(st_ret_idx_q),
        .drain_rdy(st_mem_ready), .full(st_full),
        .out_vld(st_mem_valid), .out_addr(st_mem_addr), .out_age(st_mem_age),
        .pop(st_pop), .head_idx(st_head),
        .occ(st_occ), .addrs(st_addrs), .ages(st_ages));

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (!ld_mem_valid && !st_mem_valid)); // R1

    for (genvar g = 0; g < DEPTH; g++) begin : g_order
        // a draining load never has an older same-address store behind it
        AST_RAW_ORDER: assert property (@(posedge clk) disable iff (rst)
            (ld_mem_valid && st_occ[g] && (st_addrs[g] == ld_mem_addr)) |->
                (AGE_W'(age_q - st_ages[g]) < AGE_W'(age_q - ld_mem_age))); // R5
        // a draining store never has an older same-address load still resident
        AST_WAR_ORDER: assert property (@(posedge clk) disable iff (rst)
            (st_mem_valid && ld_occ[g] && (ld_addrs[g] == st_mem_addr)) |->
                (AGE_W'(age_q - ld_ages[g]) < AGE_W'(age_q - st_mem_age))); // R6
    end

endmodule

// File: tb/fpmem_lsq_tb.sv
module fpmem_lsq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 1'b0, alloc_store = 1'b0;
    logic [31:0] alloc_addr = '0;
    logic        alloc_ready, alloc_hazard;
    logic        ld_mem_valid, st_mem_valid;
    logic        ld_mem_ready = 1'b0, st_mem_ready = 1'b0;
    logic [31:0] ld_mem_addr, st_mem_addr;
    logic [3:0]  ld_mem_age, st_mem_age;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fpmem_lsq u_dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_addr(alloc_addr),
        .alloc_ready(alloc_ready), .alloc_hazard(alloc_hazard),
        .ld_mem_valid(ld_mem_valid), .ld_mem_ready(ld_mem_ready),
        .ld_mem_addr(ld_mem_addr), .ld_mem_age(ld_mem_age),
        .st_mem_valid(st_mem_valid), .st_mem_ready(st_mem_ready),
        .st_mem_addr(st_mem_addr), .st_mem_age(st_mem_age));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // offer one operation at a negedge, check the hazard flag, take it on the edge
    task automatic put(input logic s, input logic [31:0] a, input logic hz, input string req);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_store = s; alloc_addr = a;
        #1;
        chk({req, " ready"}, 32'(alloc_ready), 32'd1);
        chk({req, " hazard"}, 32'(alloc_hazard), 32'(hz));
        @(posedge clk);
        #1 alloc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R1 ld valid", 32'(ld_mem_valid), 0);
        chk("R1 st valid", 32'(st_mem_valid), 0);
        chk("R1 ready", 32'(alloc_ready), 1);

        // R2 / R10: fill the load queue with distinct addresses
        for (int i = 0; i < 8; i++) put(1'b0, 32'h1000 + 32'(4*i), 1'b0, "R10 load fill");
        @(negedge clk);
        alloc_valid = 1'b1; alloc_store = 1'b0; #1;
        chk("R2 load full", 32'(alloc_ready), 0);
        alloc_store = 1'b1; #1;
        chk("R2 store side free", 32'(alloc_ready), 1);
        alloc_valid = 1'b0;

        // R3 / R9: drain in order with ages 0..7
        @(negedge clk) ld_mem_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #1;
            chk("R3 valid", 32'(ld_mem_valid), 1);
            chk("R3 addr", ld_mem_addr, 32'h1000 + 32'(4*i));
            chk("R9 age", 32'(ld_mem_age), 32'(i));
            @(negedge clk);
        end
        #1 chk("R3 empty", 32'(ld_mem_valid), 0);

        // R4: three stores, ages 8..10
        for (int i = 0; i < 3; i++) put(1'b1, 32'h2000 + 32'(4*i), 1'b0, "R4 store fill");
        @(negedge clk) st_mem_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R4 addr", st_mem_addr, 32'h2000 + 32'(4*i));
            chk("R9 st age", 32'(st_mem_age), 32'(8 + i));
            @(negedge clk);
        end
        st_mem_ready = 1'b0;

        // R5 / R8: RAW hold and release bubble
        put(1'b1, 32'h200, 1'b0, "R5 store");
        put(1'b0, 32'h200, 1'b1, "R5 load conflict");
        put(1'b0, 32'h300, 1'b0, "R5 load clean");
        @(negedge clk); #1 chk("R5 held", 32'(ld_mem_valid), 0);
        @(negedge clk); #1 chk("R5 still held", 32'(ld_mem_valid), 0);
        @(negedge clk) st_mem_ready = 1'b1;
        #1 chk("R5 store out", st_mem_addr, 32'h200);
        @(negedge clk) st_mem_ready = 1'b0;
        #1 chk("R8 bubble", 32'(ld_mem_valid), 0);
        @(negedge clk); #1;
        chk("R8 released", 32'(ld_mem_valid), 1);
        chk("R3 held addr", ld_mem_addr, 32'h200);
        chk("R9 held age", 32'(ld_mem_age), 12);
        @(negedge clk); #1;
        chk("R3 next addr", ld_mem_addr, 32'h300);
        chk("R9 next age", 32'(ld_mem_age), 13);
        @(negedge clk) ld_mem_ready = 1'b0;

        // R6: WAR
        st_mem_ready = 1'b1;
        put(1'b0, 32'h400, 1'b0, "R6 load");
        put(1'b1, 32'h400, 1'b1, "R6 store conflict");
        @(negedge clk); #1 chk("R6 held", 32'(st_mem_valid), 0);
        @(negedge clk) ld_mem_ready = 1'b1;
        #1 chk("R6 still held", 32'(st_mem_valid), 0);
        @(negedge clk) ld_mem_ready = 1'b0;
        #1 chk("R8 WAR bubble", 32'(st_mem_valid), 0);
        @(negedge clk); #1;
        chk("R6 released", 32'(st_mem_valid), 1);
        chk("R9 age 15", 32'(st_mem_age), 15);
        @(negedge clk) st_mem_ready = 1'b0;

        // R7: WAW across the age wrap
        put(1'b1, 32'h500, 1'b0, "R7 first");
        put(1'b1, 32'h500, 1'b1, "R7 second conflict");
        @(negedge clk) st_mem_ready = 1'b1;
        #1 chk("R9 wrap age", 32'(st_mem_age), 0);
        @(negedge clk); #1 chk("R7 bubble", 32'(st_mem_valid), 0);
        @(negedge clk); #1;
        chk("R7 released", 32'(st_mem_valid), 1);
        chk("R7 age", 32'(st_mem_age), 1);
        @(negedge clk) st_mem_ready = 1'b0;

        // R11: store retires on the same edge a matching load allocates
        put(1'b1, 32'h600, 1'b0, "R11 store");
        @(negedge clk);
        st_mem_ready = 1'b1; ld_mem_ready = 1'b1;
        alloc_valid = 1'b1; alloc_store = 1'b0; alloc_addr = 32'h600;
        #1;
        chk("R11 store leaving", 32'(st_mem_valid), 1);
        chk("R11 no hazard", 32'(alloc_hazard), 0);
        @(posedge clk); #1 alloc_valid = 1'b0;
        @(negedge clk) st_mem_ready = 1'b0;
        #1;
        chk("R10 next-cycle drain", 32'(ld_mem_valid), 1);
        chk("R11 age", 32'(ld_mem_age), 3);
        @(negedge clk) ld_mem_ready = 1'b0;

        // R2: store queue full, load side free
        for (int i = 0; i < 8; i++) put(1'b1, 32'h3000 + 32'(4*i), 1'b0, "R2 store fill");
        @(negedge clk);
        alloc_store = 1'b1; #1;
        chk("R2 store full", 32'(alloc_ready), 0);
        alloc_store = 1'b0; #1;
        chk("R2 load side free", 32'(alloc_ready), 1);

        // R1: reset empties everything, R9: age restarts
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        alloc_store = 1'b1; #1;
        chk("R1 st empty", 32'(st_mem_valid), 0);
        chk("R1 st ready", 32'(alloc_ready), 1);
        put(1'b0, 32'h700, 1'b0, "R1 post-reset load");
        @(negedge clk); #1;
        chk("R9 age restart", 32'(ld_mem_age), 0);
        chk("R1 load addr", ld_mem_addr, 32'h700);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule